// File: doc/BRIEF.md
# Instruction-Cycle Timer/Counter with Shared Prescaler

This block is the 8-bit timer/counter of a small controller core whose instruction cycle has four phases, Q1 to Q4. Each phase lasts one system clock period. The core supplies the current phase as a 2-bit index. The counter advances on one of two sources: once per instruction cycle, or on edges of an external clock pin. One 8-bit prescaler sits in front of either the counter or a watchdog timebase.

A pin edge, or a prescaler output when the prescaler feeds the counter, is not used directly. It is sampled only in the Q2 and Q4 phases. The counter then advances in a later Q4 phase. This adds a lag of several oscillator periods and lets very short pulses go unseen.

The core writes a 6-bit control word and the counter value, and reads the counter back. The watchdog side gives the block a raw pulse train. It receives that train divided by the prescaler, or passed through one to one when the counter owns the prescaler.

Top module: `tq_timer`

## Requirements
- R1: Power-on reset sets the counter to 0 and the control word to 6'h3F. In that state the counter counts falling pin edges, ignores instruction cycles, and the watchdog output fires once every 128 input pulses.
- R2: While watchdog reset (`rst_wdt`) is high, the counter keeps its value and ignores writes. The control word returns to 6'h3F (falling-edge pin mode).
- R3: With control bit 5 = 0 and the prescaler given to the watchdog, the counter advances by one in the Q4 phase of every instruction cycle.
- R4: With control bit 3 = 0, the prescaler divides the counter's source by 2^(ratio+1), where ratio is control bits 2:0. For example, ratio 0 gives 1:2 and ratio 7 gives 1:256.
- R5: In pin mode (bit 5 = 1), bit 4 = 0 counts rising pin edges and bit 4 = 1 counts falling pin edges. The other edge has no effect.
- R6: An unprescaled pin edge is sampled at the next Q2 or Q4 phase. The count changes 3, 4, 5 or 6 clock edges after the pin change. The value depends on the phase that follows the change: Q2, Q1, Q4 or Q3 respectively.
- R7: A pin pulse that is high only across a Q1 or Q3 sampling-free edge does not change the counter.
- R8: A counter write loads the value, clears the prescaler, and blocks the next two Q4 increments.
- R9: The counter wraps from 8'hFF to 8'h00. `ovf_o` is high for exactly the one cycle after the wrap.
- R10: With bit 3 = 1, the watchdog output pulses once per 2^ratio input pulses, so ratio 0 gives 1:1.
- R11: Ownership is exclusive. With bit 3 = 0, each watchdog input pulse passes straight through. With bit 3 = 1, the counter is unprescaled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one period per Q phase |
| rst_por | input | 1 | Synchronous active-high power-on reset |
| rst_wdt | input | 1 | Synchronous active-high watchdog reset |
| qph_i | input | 2 | Current phase: 0=Q1, 1=Q2, 2=Q3, 3=Q4 |
| pin_i | input | 1 | External clock pin |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: [5] pin source, [4] falling edge, [3] prescaler to watchdog, [2:0] ratio |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write value |
| wdt_src_i | input | 1 | Raw watchdog timebase pulse |
| cnt_q | output | CNT_W | Counter value |
| ovf_o | output | 1 | One-cycle wrap pulse |
| wdt_tick_o | output | 1 | Watchdog pulse after the prescaler |

## Verification
The bench builds the block with the default 8-bit counter, 8-bit prescaler and two-cycle write inhibit. These settings put both ends of the ratio range within reach: 1:2 and 1:256 for the counter, 1:1 and 1:128 for the watchdog. With an 8-bit counter, a load near 8'hFF reaches the wrap in a few instruction cycles. The bench generates the phase index itself. It can therefore place pin changes just before each of the four phases and measure the exact lag, and it can place pulses that fall between sampling points.

// File: rtl/tq_pkg.sv
package tq_pkg;

    // Control word layout; field positions are decoded by the core.
    localparam int CTL_W = 6;
    localparam int RS_W  = 3;

    typedef enum logic {
        SRC_INSN = 1'b0,
        SRC_PIN  = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } qph_e;

    typedef struct packed {
        src_e            src;
        logic            fall;
        logic            pre_wdt;
        logic [RS_W-1:0] ratio;
    } ctl_t;

    localparam logic [CTL_W-1:0] CTL_RST = 6'h3F;

endpackage

// File: rtl/tq_presc.sv
module tq_presc
    import tq_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] qph,
    input  logic       pin_i,
    input  ctl_t       ctl,
    input  logic       clr_i,
    input  logic       wdt_src_i,
    output logic       pin_lvl_o,
    output logic       tmr_carry_o,
    output logic       tmr_div_o,
    output logic       wdt_tick_o
);
    // PRE_W must be at least 2**RS_W so that every ratio has a tap.

    logic [PRE_W-1:0] presc;
    logic             pin_d;
    logic             is_q4;
    logic             own_tmr;
    logic             pin_rise;
    logic             evt;
    logic             tmr_full;
    logic             wdt_full;

    function automatic logic [PRE_W-1:0] low_ones(input int n);
        logic [PRE_W-1:0] m;
        for (int i = 0; i < PRE_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    assign is_q4     = (qph == PH_Q4);
    assign own_tmr   = !ctl.pre_wdt;
    assign pin_lvl_o = pin_i ^ ctl.fall;
    assign pin_rise  = pin_lvl_o & ~pin_d;

    always_comb begin
        if (!own_tmr) begin
            evt = wdt_src_i;
        end else if (ctl.src == SRC_PIN) begin
            evt = pin_rise;
        end else begin
            evt = is_q4;
        end
    end

    assign tmr_full    = &(presc | ~low_ones(int'(ctl.ratio) + 1));
    assign wdt_full    = &(presc | ~low_ones(int'(ctl.ratio)));
    assign tmr_carry_o = own_tmr & (ctl.src == SRC_INSN) & is_q4 & tmr_full;
    assign tmr_div_o   = presc[ctl.ratio];

    always_ff @(posedge clk) begin
        if (rst) begin
            presc      <= '0;
            pin_d      <= 1'b1;
            wdt_tick_o <= 1'b0;
        end else begin
            pin_d      <= pin_lvl_o;
            wdt_tick_o <= wdt_src_i & (own_tmr | wdt_full);
            if (clr_i) begin
                presc <= '0;
            end else if (evt) begin
                presc <= presc + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tq_sync.sv
module tq_sync
    import tq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] qph,
    input  logic       smp_i,
    output logic       inc_o
);
    logic samp;
    logic pend;
    logic is_q2;
    logic is_q4;
    logic rise;

    assign is_q2 = (qph == PH_Q2);
    assign is_q4 = (qph == PH_Q4);
    assign rise  = smp_i & ~samp;
    assign inc_o = is_q4 & pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp <= 1'b1;
            pend <= 1'b0;
        end else if (is_q2) begin
            samp <= smp_i;
            pend <= pend | rise;
        end else if (is_q4) begin
            samp <= smp_i;
            pend <= rise;
        end
    end

endmodule

// File: rtl/tq_count.sv
module tq_count
    import tq_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int INH_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_por,
    input  logic             rst_wdt,
    input  logic [1:0]       qph,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam int INH_W = $clog2(INH_CYC + 1);

    logic [INH_W-1:0] inh;
    logic             is_q4;

    assign is_q4 = (qph == PH_Q4);

    always_ff @(posedge clk) begin
        if (rst_por) begin
            cnt_o <= '0;
            inh   <= '0;
            ovf_o <= 1'b0;
        end else if (rst_wdt) begin
            inh   <= '0;
            ovf_o <= 1'b0;
        end else begin
            ovf_o <= 1'b0;
            if (we) begin
                cnt_o <= wdata;
                inh   <= INH_W'(INH_CYC);
            end else if (is_q4) begin
                if (inh != '0) begin
                    inh <= inh - 1'b1;
                end else if (inc_i) begin
                    cnt_o <= cnt_o + 1'b1;
                    ovf_o <= &cnt_o;
                end
            end
        end
    end

endmodule

// File: rtl/tq_timer.sv
module tq_timer
    import tq_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRE_W   = 8,
    parameter int INH_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_por,
    input  logic             rst_wdt,
    input  logic [1:0]       qph_i,
    input  logic             pin_i,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             wdt_src_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_o,
    output logic             wdt_tick_o
);
    ctl_t ctl_r;
    ctl_t ctl_nxt;
    logic any_rst;
    logic presc_clr;
    logic pin_lvl;
    logic tmr_carry;
    logic tmr_div;
    logic smp;
    logic sync_inc;
    logic inc;

    assign any_rst = rst_por | rst_wdt;
    assign ctl_nxt = ctl_t'(ctl_wdata);

    always_ff @(posedge clk) begin
        if (any_rst) begin
            ctl_r <= ctl_t'(CTL_RST);
        end else if (ctl_we) begin
            ctl_r <= ctl_nxt;
        end
    end

    // Prescaler restarts on a counter load or an ownership change.
    assign presc_clr = cnt_we | (ctl_we & (ctl_nxt.pre_wdt != ctl_r.pre_wdt));

    tq_presc #(.PRE_W(PRE_W)) u_presc (
        .clk         (clk),
        .rst         (any_rst),
        .qph         (qph_i),
        .pin_i       (pin_i),
        .ctl         (ctl_r),
        .clr_i       (presc_clr),
        .wdt_src_i   (wdt_src_i),
        .pin_lvl_o   (pin_lvl),
        .tmr_carry_o (tmr_carry),
        .tmr_div_o   (tmr_div),
        .wdt_tick_o  (wdt_tick_o)
    );

    always_comb begin
        if (ctl_r.src == SRC_PIN) begin
            smp = ctl_r.pre_wdt ? pin_lvl : tmr_div;
        end else begin
            smp = 1'b0;
        end
    end

    tq_sync u_sync (
        .clk   (clk),
        .rst   (any_rst),
        .qph   (qph_i),
        .smp_i (smp),
        .inc_o (sync_inc)
    );

    always_comb begin
        if (ctl_r.src == SRC_PIN) begin
            inc = sync_inc;
        end else if (ctl_r.pre_wdt) begin
            inc = (qph_i == PH_Q4);
        end else begin
            inc = tmr_carry;
        end
    end

    tq_count #(.CNT_W(CNT_W), .INH_CYC(INH_CYC)) u_count (
        .clk     (clk),
        .rst_por (rst_por),
        .rst_wdt (rst_wdt),
        .qph     (qph_i),
        .we      (cnt_we),
        .wdata   (cnt_wdata),
        .inc_i   (inc),
        .cnt_o   (cnt_q),
        .ovf_o   (ovf_o)
    );

endmodule

// File: rtl/tq_timer_chk.sv
module tq_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_por,
    input logic             rst_wdt,
    input logic [1:0]       qph_i,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_o,
    input logic             wdt_src_i,
    input logic             wdt_tick_o,
    input logic             pre_wdt
);
    // R9: a wrap pulse only follows an all-ones to zero step
    p_ovf_wrap_r9: assert property (@(posedge clk) disable iff (rst_por || rst_wdt)
        ovf_o |-> (cnt_q == '0 && $past(cnt_q) == '1));

    // R3: without a load, the counter holds or steps by one
    p_step_one_r3: assert property (@(posedge clk) disable iff (rst_por)
        (!$past(cnt_we) && !$past(rst_por)) |->
        (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R6: increments only land in the Q4 phase
    p_inc_in_q4_r6: assert property (@(posedge clk) disable iff (rst_por)
        (!$past(cnt_we) && !$past(rst_por) && cnt_q != $past(cnt_q)) |->
        ($past(qph_i) == 2'd3));

    // R2: watchdog reset freezes the counter
    p_wdt_hold_r2: assert property (@(posedge clk) disable iff (rst_por)
        $past(rst_wdt) |-> (cnt_q == $past(cnt_q)));

    // R11: with the timer owning the prescaler the watchdog pulses pass through
    p_wdt_direct_r11: assert property (@(posedge clk) disable iff (rst_por || rst_wdt)
        (!$past(rst_por) && !$past(rst_wdt) && !$past(pre_wdt)) |->
        (wdt_tick_o == $past(wdt_src_i)));

    // R10: every watchdog output pulse comes from an input pulse
    p_tick_has_src_r10: assert property (@(posedge clk) disable iff (rst_por || rst_wdt)
        wdt_tick_o |-> $past(wdt_src_i));

endmodule

bind tq_timer tq_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_por    (rst_por),
    .rst_wdt    (rst_wdt),
    .qph_i      (qph_i),
    .cnt_we     (cnt_we),
    .cnt_q      (cnt_q),
    .ovf_o      (ovf_o),
    .wdt_src_i  (wdt_src_i),
    .wdt_tick_o (wdt_tick_o),
    .pre_wdt    (ctl_r.pre_wdt)
);

// File: tb/sim_tq_timer.sv
`timescale 1ns/1ps
module sim_tq_timer;

    logic       clk = 1'b0;
    logic       rst_por;
    logic       rst_wdt;
    logic [1:0] ph;
    logic       pin;
    logic       ctl_we;
    logic [5:0] ctl_wdata;
    logic       cnt_we;
    logic [7:0] cnt_wdata;
    logic       wdt_src;
    logic [7:0] cnt_q;
    logic       ovf;
    logic       wdt_tick;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    tq_timer u0 (
        .clk        (clk),
        .rst_por    (rst_por),
        .rst_wdt    (rst_wdt),
        .qph_i      (ph),
        .pin_i      (pin),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .wdt_src_i  (wdt_src),
        .cnt_q      (cnt_q),
        .ovf_o      (ovf),
        .wdt_tick_o (wdt_tick)
    );

    // Phase index: at a falling edge, ph names the phase of the next rising edge.
    initial begin
        ph = 2'd0;
        forever begin
            @(posedge clk);
            #2 ph = ph + 2'd1;
        end
    end

    task automatic chk(input string req, input int act, input int exp_v);
        nchk++;
        if (act != exp_v) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_phase(input int k);
        @(negedge clk);
        while (int'(ph) != k) @(negedge clk);
    endtask

    // Control and counter written together at a Q1 edge.
    task automatic cfg(input logic [5:0] c, input logic [7:0] v);
        go_phase(0);
        ctl_we = 1'b1; ctl_wdata = c;
        cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0; cnt_we = 1'b0;
    endtask

    task automatic wdt_pulses(input int n, output int ticks);
        ticks = 0;
        for (int i = 0; i < n; i++) begin
            wdt_src = 1'b1;
            @(negedge clk);
            wdt_src = 1'b0;
            if (wdt_tick) ticks++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int t;
        chk("R1 count after reset", cnt_q, 0);
        chk("R1 ovf after reset", ovf, 0);
        chk("R1 tick after reset", wdt_tick, 0);
        wait_edges(40);
        chk("R1 no instruction counting", cnt_q, 0);
        pin = 1'b1; wait_edges(12);
        chk("R1 rising edge ignored", cnt_q, 0);
        pin = 1'b0; wait_edges(12);
        chk("R1 falling edge counted", cnt_q, 1);
        wdt_pulses(127, t);
        chk("R1 no tick before 128 pulses", t, 0);
        wdt_pulses(1, t);
        chk("R1 tick at pulse 128", t, 1);
    endtask

    task automatic t_insn();
        cfg(6'h08, 8'h10);
        wait_edges(10);
        chk("R8 held two Q4 after load", cnt_q, 8'h10);
        wait_edges(1);
        chk("R8 first increment third Q4", cnt_q, 8'h11);
        wait_edges(40);
        chk("R3 R11 one per instruction cycle", cnt_q, 8'h1B);
    endtask

    task automatic t_write_clear();
        cfg(6'h01, 8'h20);
        wait_edges(14);
        chk("R8 prescaler cleared, no step yet", cnt_q, 8'h20);
        wait_edges(1);
        chk("R8 step after four cycles", cnt_q, 8'h21);
    endtask

    task automatic t_presc();
        int rs[3] = '{0, 2, 7};
        int ms[3] = '{4, 2, 2};
        for (int i = 0; i < 3; i++) begin
            int c0;
            cfg(6'(rs[i]), 8'h00);
            wait_edges(40);
            c0 = int'(cnt_q);
            wait_edges(4 * ms[i] * (2 << rs[i]));
            chk($sformatf("R4 ratio %0d step count", rs[i]), int'(cnt_q) - c0, ms[i]);
        end
    endtask

    task automatic t_latency();
        int lat[4] = '{4, 3, 6, 5};
        cfg(6'h28, 8'h00);
        wait_edges(16);
        for (int k = 0; k < 4; k++) begin
            int c0;
            int n;
            go_phase(k);
            c0 = int'(cnt_q);
            pin = 1'b1;
            n = 0;
            for (int j = 0; j < 10; j++) begin
                @(negedge clk);
                n++;
                if (int'(cnt_q) != c0) break;
            end
            chk($sformatf("R6 lag before phase %0d", k), n, lat[k]);
            chk("R5 rising edge counted", int'(cnt_q), c0 + 1);
            pin = 1'b0;
            wait_edges(12);
            chk("R5 falling edge ignored", int'(cnt_q), c0 + 1);
        end
    endtask

    task automatic t_fall();
        cfg(6'h38, 8'h00);
        wait_edges(16);
        chk("R5 settle in falling mode", cnt_q, 0);
        pin = 1'b1; wait_edges(12);
        chk("R5 rising ignored in falling mode", cnt_q, 0);
        pin = 1'b0; wait_edges(12);
        chk("R5 falling counted", cnt_q, 1);
        for (int i = 0; i < 2; i++) begin
            pin = 1'b1; wait_edges(12);
            pin = 1'b0; wait_edges(12);
        end
        chk("R5 three falling edges", cnt_q, 3);
    endtask

    task automatic t_short();
        cfg(6'h28, 8'h00);
        wait_edges(16);
        go_phase(2);
        pin = 1'b1;
        @(negedge clk);
        pin = 1'b0;
        wait_edges(12);
        chk("R7 pulse across Q3 only missed", cnt_q, 0);
        go_phase(1);
        pin = 1'b1;
        @(negedge clk);
        pin = 1'b0;
        wait_edges(12);
        chk("R7 pulse across Q2 counted", cnt_q, 1);
    endtask

    task automatic t_wrap();
        cfg(6'h08, 8'hFD);
        wait_edges(18);
        chk("R9 reaches FF", cnt_q, 8'hFF);
        chk("R9 no ovf before wrap", ovf, 0);
        wait_edges(1);
        chk("R9 wraps to 00", cnt_q, 8'h00);
        chk("R9 ovf on wrap", ovf, 1);
        wait_edges(1);
        chk("R9 ovf lasts one cycle", ovf, 0);
    endtask

    task automatic t_wdt();
        int t;
        cfg(6'h0B, 8'h00);
        wdt_pulses(7, t);
        chk("R10 1:8 no tick in 7", t, 0);
        wdt_pulses(1, t);
        chk("R10 1:8 tick at 8", t, 1);
        wdt_pulses(16, t);
        chk("R10 1:8 two ticks in 16", t, 2);
        cfg(6'h08, 8'h00);
        wdt_pulses(4, t);
        chk("R10 1:1 ratio", t, 4);
        cfg(6'h00, 8'h00);
        wdt_pulses(5, t);
        chk("R11 timer owns prescaler, watchdog direct", t, 5);
    endtask

    task automatic t_wdt_rst();
        cfg(6'h28, 8'h55);
        wait_edges(16);
        chk("R2 loaded", cnt_q, 8'h55);
        rst_wdt = 1'b1;
        cnt_we = 1'b1; cnt_wdata = 8'hAA;
        wait_edges(3);
        rst_wdt = 1'b0;
        cnt_we = 1'b0;
        chk("R2 count kept, write ignored", cnt_q, 8'h55);
        wait_edges(8);
        chk("R2 no instruction counting", cnt_q, 8'h55);
        pin = 1'b1; wait_edges(12);
        chk("R2 control back to falling mode", cnt_q, 8'h55);
        pin = 1'b0; wait_edges(12);
        chk("R2 falling edge counted", cnt_q, 8'h56);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst_por = 1'b1; rst_wdt = 1'b0; pin = 1'b0;
        ctl_we = 1'b0; ctl_wdata = '0;
        cnt_we = 1'b0; cnt_wdata = '0; wdt_src = 1'b0;
        wait_edges(4);
        rst_por = 1'b0;
        @(negedge clk);
        t_reset();
        t_insn();
        t_write_clear();
        t_presc();
        t_latency();
        t_fall();
        t_short();
        t_wrap();
        t_wdt();
        t_wdt_rst();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule